// File: doc/BRIEF.md
# PWM Timebase Counter with Phase Sync

This block is the time reference for a pulse-width modulation generator. A programmable prescaler divides the system clock. On each prescaled tick a 16-bit counter steps in one of three modes: rising, falling, or rising then falling. The counter is bounded by a period value that is either written straight into use or held in a shadow copy until the next zero event. The compare and output stages downstream read the counter value and two one-clock strobes. One strobe marks the counter reaching zero. The other marks it reaching the period.

Several timebases can be locked together. An external sync input loads a programmable phase value into the counter and restarts the prescaler. The sync output stays high for one prescaled tick after each zero event, so a chain of modules stays aligned. A per-module enable freezes the counter, the prescaler and the sync logic. An interrupt request flag latches an enabled zero or period strobe and stays set until cleared.

The counting direction in the rise-then-fall mode is held by a two-state machine:
- `CNT_RISE` moves to `CNT_FALL` when the count steps onto the period, or when a tick finds the count at or above the period.
- `CNT_FALL` moves to `CNT_RISE` when the count steps onto zero, or when a tick finds the count already at zero.
- The rising mode forces the state to `CNT_RISE`, and the falling mode forces it to `CNT_FALL`.

Top module: `pwm_timebase`

## Requirements
- R1: While reset is held, and in the first cycle after it, `cnt` is 0 and `evt_zero`, `evt_per`, `sync_out` and `irq` are low. The active and shadow period both reset to 16'hFFFF.
- R2: With `en` high, the counter changes once every D system clocks, where D is `cfg_div`. A `cfg_div` of 0 behaves as a divide by 1. The first tick comes D clocks after reset release or after a sync load.
- R3: With `cfg_mode` 0 (code 3 behaves the same), each tick adds one to the count. A tick that finds the count at or above the period P loads 0 instead.
- R4: With `cfg_mode` 1, each tick subtracts one from the count. A tick that finds the count at 0 loads P instead.
- R5: With `cfg_mode` 2, the count runs 0,1,…,P,P-1,…,1,0,1,… Each turning value is held for exactly one tick. With P = 0 the count stays at 0.
- R6: `evt_zero` is high for one clock in the cycle after a tick that loads 0. `evt_per` is high for one clock in the cycle after a tick that loads a value equal to the active period in use on that tick. Both strobes fire together when P = 0.
- R7: With `cfg_shadow` low, a write through `per_we`/`per_wdata` becomes the active period from the next clock onward.
- R8: With `cfg_shadow` high, a write changes only the shadow copy. The shadow copy becomes active on the clock of the next tick that loads 0. A write in that same clock is the value that becomes active.
- R9: When `en` and `sync_in` are both high, the next clock loads `cfg_phase` into the counter and clears the prescaler. No tick and no strobe happen in that clock, and the direction state is kept.
- R10: `sync_out` rises together with `evt_zero`. It falls on the next tick, so it stays high for one prescaled period. It goes low one clock after `en` falls.
- R11: With `en` low, the counter, the prescaler and the direction state all hold their values. No strobe fires, and `sync_in` is ignored.
- R12: `irq` goes high the clock after `evt_zero` while `irq_zero_en` is high, or after `evt_per` while `irq_per_en` is high. `irq_clr` clears it. A set and a clear in the same clock leave it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Module enable; low freezes the timebase |
| cfg_div | input | 8 | Prescale divide value, 0 acts as 1 |
| cfg_mode | input | 2 | 0 rise, 1 fall, 2 rise-then-fall, 3 as rise |
| cfg_shadow | input | 1 | High routes period writes through the shadow copy |
| cfg_phase | input | 16 | Value loaded into the counter on sync |
| per_we | input | 1 | Period write strobe |
| per_wdata | input | 16 | Period write data |
| sync_in | input | 1 | Phase load request from an upstream timebase |
| irq_zero_en | input | 1 | Zero strobe may set the interrupt flag |
| irq_per_en | input | 1 | Period strobe may set the interrupt flag |
| irq_clr | input | 1 | Clears the interrupt flag |
| cnt | output | 16 | Counter value |
| evt_zero | output | 1 | One-clock strobe, counter reached zero |
| evt_per | output | 1 | One-clock strobe, counter reached the period |
| sync_out | output | 1 | Cascade sync, high for one prescaled tick per zero event |
| irq | output | 1 | Interrupt request flag |

## Verification
Two events can fall in the same clock. One is a shadowed period write that lands on the tick that wraps the counter to zero. The other is an interrupt clear that lands on a set from a strobe. The bench watches its own reference model and raises `per_we` in the exact cycle it predicts a wrap. It then checks that the newly written value, not the stale shadow copy, bounds the next count cycle. It also raises `irq_clr` in the cycle a strobe is visible and expects `irq` to stay set. Seeded random traffic then mixes writes, syncs, enable gaps and mode changes, so that these collisions and a sync landing on a tick recur many times.

// File: rtl/pwm_timebase_pkg.sv
package pwm_timebase_pkg;

    typedef enum logic [1:0] {
        MODE_RISE   = 2'd0,
        MODE_FALL   = 2'd1,
        MODE_UPDOWN = 2'd2,
        MODE_RSV    = 2'd3
    } cnt_mode_e;

    typedef enum logic {
        CNT_RISE = 1'b0,
        CNT_FALL = 1'b1
    } dir_state_e;

endpackage

// File: rtl/ptb_prescaler.sv
module ptb_prescaler #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             restart_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    logic [DIV_W-1:0] pre_q;
    logic [DIV_W-1:0] eff_div;

    assign eff_div = (div_i == '0) ? ONE : div_i;
    assign tick_o  = en_i && !restart_i && (pre_q >= eff_div - ONE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (en_i) begin
            if (restart_i || tick_o) begin
                pre_q <= '0;
            end else begin
                pre_q <= pre_q + ONE;
            end
        end
    end

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> (!tick_o || eff_div == ONE)); // R2

endmodule

// File: rtl/ptb_period_reg.sv
module ptb_period_reg #(
    parameter int              CNT_W   = 16,
    parameter logic [CNT_W-1:0] PER_RST = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shadow_i,
    input  logic             we_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic             zero_tick_i,
    output logic [CNT_W-1:0] per_o
);
    logic [CNT_W-1:0] shd_q;
    logic [CNT_W-1:0] act_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shd_q <= PER_RST;
        end else if (we_i) begin
            shd_q <= wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q <= PER_RST;
        end else if (we_i && !shadow_i) begin
            act_q <= wdata_i;
        end else if (shadow_i && zero_tick_i) begin
            act_q <= we_i ? wdata_i : shd_q;
        end
    end

    assign per_o = act_q;

    AST_DIRECT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && !shadow_i) |=> (per_o == $past(wdata_i))); // R7

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (shadow_i && !zero_tick_i) |=> $stable(per_o)); // R8

endmodule

// File: rtl/ptb_counter.sv
module ptb_counter
    import pwm_timebase_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             tick_i,
    input  logic             sync_i,
    input  logic [CNT_W-1:0] phase_i,
    input  cnt_mode_e        mode_i,
    input  logic [CNT_W-1:0] per_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             zero_tick_o,
    output logic             evt_zero_o,
    output logic             evt_per_o,
    output logic             sync_o
);
    localparam logic [CNT_W-1:0] ZERO = '0;
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    dir_state_e       state_q, nxt_state;
    logic [CNT_W-1:0] cnt_q, nxt_cnt;

    // next count and direction for one tick
    always_comb begin
        nxt_cnt   = cnt_q;
        nxt_state = state_q;
        case (mode_i)
            MODE_FALL: begin
                nxt_state = CNT_FALL;
                nxt_cnt   = (cnt_q == ZERO) ? per_i : cnt_q - ONE;
            end
            MODE_UPDOWN: begin
                unique case (state_q)
                    CNT_RISE: begin
                        if (cnt_q >= per_i) begin
                            nxt_state = CNT_FALL;
                            nxt_cnt   = (cnt_q == ZERO) ? ZERO : cnt_q - ONE;
                        end else begin
                            nxt_cnt   = cnt_q + ONE;
                            nxt_state = (cnt_q + ONE == per_i) ? CNT_FALL : CNT_RISE;
                        end
                    end
                    CNT_FALL: begin
                        if (cnt_q == ZERO) begin
                            nxt_state = CNT_RISE;
                            nxt_cnt   = (per_i == ZERO) ? ZERO : ONE;
                        end else begin
                            nxt_cnt   = cnt_q - ONE;
                            nxt_state = (cnt_q == ONE) ? CNT_RISE : CNT_FALL;
                        end
                    end
                endcase
            end
            default: begin
                nxt_state = CNT_RISE;
                nxt_cnt   = (cnt_q >= per_i) ? ZERO : cnt_q + ONE;
            end
        endcase
    end

    assign zero_tick_o = tick_i && (nxt_cnt == ZERO);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CNT_RISE;
        end else if (tick_i) begin
            state_q <= nxt_state;
        end
    end

    // outputs: count, strobes, cascade sync
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q      <= ZERO;
            evt_zero_o <= 1'b0;
            evt_per_o  <= 1'b0;
            sync_o     <= 1'b0;
        end else begin
            evt_zero_o <= zero_tick_o;
            evt_per_o  <= tick_i && (nxt_cnt == per_i);
            if (en_i && sync_i) begin
                cnt_q <= phase_i;
            end else if (tick_i) begin
                cnt_q <= nxt_cnt;
            end
            if (!en_i) begin
                sync_o <= 1'b0;
            end else if (zero_tick_o) begin
                sync_o <= 1'b1;
            end else if (tick_i) begin
                sync_o <= 1'b0;
            end
        end
    end

    assign cnt_o = cnt_q;

    AST_SYNC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && sync_i) |=> (cnt_o == $past(phase_i))); // R9

    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> ($stable(cnt_o) && !evt_zero_o && !evt_per_o)); // R11

    AST_PER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        evt_per_o |-> (cnt_o == $past(per_i))); // R6

    AST_SYNCOUT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !sync_o); // R10

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm_timebase_pkg::*;
#(
    parameter int               CNT_W   = 16,
    parameter int               DIV_W   = 8,
    parameter logic [CNT_W-1:0] PER_RST = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic [1:0]       cfg_mode,
    input  logic             cfg_shadow,
    input  logic [CNT_W-1:0] cfg_phase,
    input  logic             per_we,
    input  logic [CNT_W-1:0] per_wdata,
    input  logic             sync_in,
    input  logic             irq_zero_en,
    input  logic             irq_per_en,
    input  logic             irq_clr,
    output logic [CNT_W-1:0] cnt,
    output logic             evt_zero,
    output logic             evt_per,
    output logic             sync_out,
    output logic             irq
);
    logic             tick;
    logic             zero_tick;
    logic             sync_load;
    logic             irq_set;
    logic [CNT_W-1:0] per_act;

    assign sync_load = en && sync_in;

    ptb_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (en),
        .restart_i (sync_load),
        .div_i     (cfg_div),
        .tick_o    (tick)
    );

    ptb_period_reg #(.CNT_W(CNT_W), .PER_RST(PER_RST)) u_per (
        .clk         (clk),
        .rst_n       (rst_n),
        .shadow_i    (cfg_shadow),
        .we_i        (per_we),
        .wdata_i     (per_wdata),
        .zero_tick_i (zero_tick),
        .per_o       (per_act)
    );

    ptb_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (en),
        .tick_i      (tick),
        .sync_i      (sync_in),
        .phase_i     (cfg_phase),
        .mode_i      (cnt_mode_e'(cfg_mode)),
        .per_i       (per_act),
        .cnt_o       (cnt),
        .zero_tick_o (zero_tick),
        .evt_zero_o  (evt_zero),
        .evt_per_o   (evt_per),
        .sync_o      (sync_out)
    );

    assign irq_set = (evt_zero && irq_zero_en) || (evt_per && irq_per_en);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else if (irq_set) begin
            irq <= 1'b1;
        end else if (irq_clr) begin
            irq <= 1'b0;
        end
    end

    AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_zero && irq_zero_en) || (evt_per && irq_per_en)) |=> irq); // R12

    AST_ZERO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        evt_zero |-> (cnt == '0)); // R6

    AST_SYNC_WITH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        evt_zero |-> sync_out); // R10

endmodule

// File: tb/pwm_timebase_tb.sv
`timescale 1ns/1ps
module pwm_timebase_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b1;
    logic [7:0]  cfg_div = 8'd1;
    logic [1:0]  cfg_mode = 2'd0;
    logic        cfg_shadow = 1'b0;
    logic [15:0] cfg_phase = 16'd0;
    logic        per_we = 1'b0;
    logic [15:0] per_wdata = 16'd0;
    logic        sync_in = 1'b0;
    logic        irq_zero_en = 1'b0;
    logic        irq_per_en = 1'b0;
    logic        irq_clr = 1'b0;
    logic [15:0] cnt;
    logic        evt_zero, evt_per, sync_out, irq;

    pwm_timebase u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .cfg_div(cfg_div), .cfg_mode(cfg_mode),
        .cfg_shadow(cfg_shadow), .cfg_phase(cfg_phase), .per_we(per_we),
        .per_wdata(per_wdata), .sync_in(sync_in), .irq_zero_en(irq_zero_en),
        .irq_per_en(irq_per_en), .irq_clr(irq_clr), .cnt(cnt), .evt_zero(evt_zero),
        .evt_per(evt_per), .sync_out(sync_out), .irq(irq)
    );

    always #2.5 clk = ~clk;

    int    checks = 0;
    int    fails = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // reference model state
    int          m_pre;
    logic [15:0] m_cnt, m_per, m_shd;
    bit          m_rise, m_ez, m_ep, m_so, m_irq;

    function automatic void next_of(input int mode, input logic [15:0] c,
                                    input logic [15:0] p, input bit rise,
                                    output logic [15:0] nc, output bit nr);
        if (mode == 1) begin
            nr = 1'b0;
            nc = (c == 0) ? p : c - 16'd1;
        end else if (mode == 2) begin
            if (rise) begin
                if (c >= p) begin nr = 1'b0; nc = (c == 0) ? 16'd0 : c - 16'd1; end
                else begin nc = c + 16'd1; nr = (nc != p); end
            end else begin
                if (c == 0) begin nr = 1'b1; nc = (p == 0) ? 16'd0 : 16'd1; end
                else begin nc = c - 16'd1; nr = (nc == 0); end
            end
        end else begin
            nr = 1'b1;
            nc = (c >= p) ? 16'd0 : c + 16'd1;
        end
    endfunction

    always @(posedge clk) begin
        int          eff;
        bit          tk, zt, nr;
        logic [15:0] nc, old_shd;
        if (!rst_n) begin
            m_pre = 0; m_cnt = 0; m_rise = 1'b1; m_per = 16'hFFFF; m_shd = 16'hFFFF;
            m_ez = 0; m_ep = 0; m_so = 0; m_irq = 0;
        end else begin
            eff = (cfg_div == 0) ? 1 : int'(cfg_div);
            tk  = en && !sync_in && (m_pre >= eff - 1);
            next_of(int'(cfg_mode), m_cnt, m_per, m_rise, nc, nr);
            zt  = tk && (nc == 0);
            if ((m_ez && irq_zero_en) || (m_ep && irq_per_en)) m_irq = 1'b1;
            else if (irq_clr) m_irq = 1'b0;
            m_ep = tk && (nc == m_per);
            m_ez = zt;
            if (!en) m_so = 1'b0;
            else if (zt) m_so = 1'b1;
            else if (tk) m_so = 1'b0;
            old_shd = m_shd;
            if (per_we) m_shd = per_wdata;
            if (per_we && !cfg_shadow) m_per = per_wdata;
            else if (cfg_shadow && zt) m_per = per_we ? per_wdata : old_shd;
            if (en && sync_in) m_cnt = cfg_phase;
            else if (tk) begin m_cnt = nc; m_rise = nr; end
            if (en) m_pre = (sync_in || tk) ? 0 : m_pre + 1;
        end
    end

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic compare();
        chk(cur_req, "cnt", {16'd0, cnt}, {16'd0, m_cnt});
        chk("R6", "strobes", {30'd0, evt_zero, evt_per}, {30'd0, m_ez, m_ep});
        chk("R10", "sync_out", {31'd0, sync_out}, {31'd0, m_so});
        chk("R12", "irq", {31'd0, irq}, {31'd0, m_irq});
    endtask

    task automatic cycles(input int n);
        repeat (n) begin
            @(negedge clk);
            compare();
        end
    endtask

    task automatic wr_per(input logic [15:0] v);
        per_we = 1'b1; per_wdata = v;
        cycles(1);
        per_we = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired before the run completed");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "cnt in reset", {16'd0, cnt}, 32'd0);
        chk("R1", "flags in reset", {28'd0, evt_zero, evt_per, sync_out, irq}, 32'd0);
        rst_n = 1'b1;
        cycles(1);
        chk("R1", "count after first tick", {16'd0, cnt}, 32'd1);

        // R7: unshadowed period, then R3 rising mode
        cur_req = "R7";
        wr_per(16'd9);
        cycles(15);
        cur_req = "R3";
        cycles(30);
        cfg_mode = 2'd3;
        cycles(25);
        cfg_mode = 2'd0;

        // R2: divide by 3, then 0 acting as 1
        cur_req = "R2";
        cfg_div = 8'd3;
        cycles(60);
        cfg_div = 8'd0;
        cycles(25);
        cfg_div = 8'd1;

        // R4: falling mode
        cur_req = "R4";
        cfg_mode = 2'd1;
        cycles(40);

        // R5: rise-then-fall with several periods including 1 and 0
        cur_req = "R5";
        cfg_mode = 2'd2;
        wr_per(16'd5);
        cycles(40);
        wr_per(16'd1);
        cycles(12);
        wr_per(16'd0);
        cycles(10);
        chk("R5", "held at zero", {16'd0, cnt}, 32'd0);
        wr_per(16'd6);
        cycles(30);

        // R8: shadowed write, and a write landing on the wrap tick
        cur_req = "R8";
        cfg_mode = 2'd0;
        cfg_shadow = 1'b1;
        cycles(3);
        wr_per(16'd3);
        cycles(20);
        for (int k = 0; k < 40; k++) begin
            if (m_cnt == m_per) break;
            cycles(1);
        end
        wr_per(16'd11);
        cycles(1);
        chk("R8", "wrap after coincident write", {16'd0, cnt}, 32'd1);
        cycles(30);
        cfg_shadow = 1'b0;

        // R9: sync loads phase, also mid-prescale and in rise-then-fall
        cur_req = "R9";
        cfg_phase = 16'd7;
        sync_in = 1'b1;
        cycles(1);
        sync_in = 1'b0;
        chk("R9", "phase loaded", {16'd0, cnt}, 32'd7);
        cycles(10);
        cfg_div = 8'd4;
        cycles(6);
        cfg_phase = 16'd2;
        sync_in = 1'b1;
        cycles(1);
        sync_in = 1'b0;
        cycles(30);
        cfg_mode = 2'd2;
        cycles(9);
        sync_in = 1'b1;
        cycles(1);
        sync_in = 1'b0;
        cycles(40);

        // R10: cascade sync width with divide 4
        cur_req = "R10";
        cfg_mode = 2'd0;
        wr_per(16'd4);
        cycles(60);

        // R11: disabled, sync and writes attempted
        cur_req = "R11";
        en = 1'b0;
        sync_in = 1'b1;
        cycles(20);
        sync_in = 1'b0;
        en = 1'b1;
        cycles(25);

        // R12: interrupt set, clear, clear colliding with a strobe
        cur_req = "R12";
        cfg_div = 8'd1;
        irq_zero_en = 1'b1;
        cycles(12);
        irq_clr = 1'b1;
        cycles(1);
        irq_clr = 1'b0;
        for (int k = 0; k < 20; k++) begin
            if (m_ez) break;
            cycles(1);
        end
        irq_clr = 1'b1;
        cycles(1);
        irq_clr = 1'b0;
        chk("R12", "set beats clear", {31'd0, irq}, 32'd1);
        irq_per_en = 1'b1;
        irq_zero_en = 1'b0;
        cycles(20);

        // seeded random mix
        for (int i = 0; i < 15000; i++) begin
            if (i % 300 == 0) begin
                cfg_mode    = 2'($urandom_range(0, 3));
                cfg_div     = 8'($urandom_range(0, 4));
                cfg_shadow  = 1'($urandom_range(0, 1));
                irq_zero_en = 1'($urandom_range(0, 1));
                irq_per_en  = 1'($urandom_range(0, 1));
            end
            per_we    = ($urandom_range(0, 15) == 0);
            per_wdata = 16'($urandom_range(0, 12));
            sync_in   = ($urandom_range(0, 49) == 0);
            cfg_phase = 16'($urandom_range(0, 14));
            en        = ($urandom_range(0, 19) != 0);
            irq_clr   = ($urandom_range(0, 7) == 0);
            cur_req   = (cfg_mode == 2'd1) ? "R4" : (cfg_mode == 2'd2) ? "R5" : "R3";
            cycles(1);
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule